// File: doc/BRIEF.md
# Full-Speed USB Device Endpoint Control and Handshake Unit

This block holds the control word of one USB device IN endpoint and decides, for every token the protocol engine reports, which handshake goes back to the host: ACK, NAK, STALL, or "send the data packet". Software reads and writes the control word through a single-register write/read port. The protocol engine reports token arrival (IN or SETUP), whether the transmit FIFO has a packet ready, a core-initiated NAK request, and the completion of a SETUP phase or of a transfer. The block answers one cycle after each token and raises single-cycle interrupt pulses for setup-done, transfer-complete and endpoint-disabled.

The enable bit is cleared by hardware strictly before any of these interrupts rises, so an interrupt handler never observes an endpoint that still looks enabled. A parameter selects the control-endpoint variant, which has a 2-bit coded packet size and an always-active flag, or the general variant with a raw packet-size field whose whole word resets to zero.

Top module: `usb_ep_ctrl`

## Requirements
- R1: After reset the general variant reads 0 and the control variant reads only bit 11 (active) set; `hs_valid` and all interrupt outputs are 0.
- R2: An IN token seen while the NAK flag (bit 12) is 1 and stall (bit 13) is 0 is answered with NAK (code 2) even when `fifo_has_data` is 1; every answer appears on `hs_code` with `hs_valid` high in the cycle after `tok_valid`; codes are DATA=0, ACK=1, NAK=2, STALL=3.
- R3: With NAK flag 0 and stall 0, an IN token on an enabled endpoint (bit 21) gives DATA when `fifo_has_data` is 1 and NAK when it is 0; on a disabled endpoint it gives NAK.
- R4: A SETUP token (`tok_setup` 1) is always answered with ACK, whatever the stall, NAK and enable bits.
- R5: An IN token with stall set gives STALL, ahead of every NAK cause.
- R6: Writing bit 16 sets the NAK flag, writing bit 17 clears it, and writing both sets it; `core_set_nak` also sets it and beats a clear; bits 16 and 17 always read 0.
- R7: In the control variant the packet-size code in bits 1:0 gives `mps_bytes` 00→64, 01→32, 10→16, 11→8, and bits 10:2 read 0; the general variant passes bits 10:0 straight through.
- R8: In the control variant bit 11 reads 1 whatever is written.
- R9: Writing 1 to bit 21 sets enable and writing 0 leaves it; `setup_done` or `xfer_done` clears enable at that edge, and the matching interrupt is high for one cycle starting one cycle later, so enable has already read 0 for a full cycle.
- R10: Writing bit 20 while enabled sets the disable bit; on the next edge enable and disable both clear and one cycle later `irq_ep_disabled` pulses; writing bit 20 while disabled is ignored and the bit reads 0.
- R11: A hardware clear of enable in the same cycle as a software write setting it leaves enable at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe for the control word |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Current control word |
| tok_valid | input | 1 | A token addressed to this endpoint arrived |
| tok_setup | input | 1 | 1 for SETUP, 0 for IN |
| fifo_has_data | input | 1 | Transmit FIFO holds a packet |
| core_set_nak | input | 1 | Protocol engine forces the NAK flag |
| setup_done | input | 1 | SETUP phase completed |
| xfer_done | input | 1 | Transfer completed |
| hs_valid | output | 1 | Handshake decision valid |
| hs_code | output | 2 | Handshake decision |
| mps_bytes | output | MPS_W | Decoded maximum packet size in bytes |
| irq_setup_done | output | 1 | Setup-done interrupt pulse |
| irq_xfer_done | output | 1 | Transfer-complete interrupt pulse |
| irq_ep_disabled | output | 1 | Endpoint-disabled interrupt pulse |

## Verification
Every cycle the assertions check the handshake priority (SETUP acknowledged, stall before NAK, NAK flag overriding FIFO data), that the command bits never read back, that set-NAK wins, that a pending disable clears enable at the next edge, and that no interrupt rises unless enable read 0 in the previous cycle. What only the bench scenarios show is the full sequence of values: the exact cycle each interrupt pulses, the packet-size decode, writes of enable or disable that must be ignored, and the reset words of both variants, all compared against a reference model over long random runs.

// File: rtl/usb_epctl_pkg.sv
package usb_epctl_pkg;

   typedef enum logic [1:0] {
      HS_DATA  = 2'd0,
      HS_ACK   = 2'd1,
      HS_NAK   = 2'd2,
      HS_STALL = 2'd3
   } hs_e;

   localparam int unsigned B_ACT   = 11;
   localparam int unsigned B_NAK   = 12;
   localparam int unsigned B_STALL = 13;
   localparam int unsigned B_SNAK  = 16;
   localparam int unsigned B_CNAK  = 17;
   localparam int unsigned B_DIS   = 20;
   localparam int unsigned B_ENA   = 21;
   localparam int unsigned TOP_BIT = B_ENA;

   typedef struct packed {
      logic ena;
      logic dis;
      logic nak;
      logic stall;
      logic act;
   } ctl_s;

   localparam int unsigned N_IRQ  = 3;
   localparam int unsigned IRQ_SU = 0;
   localparam int unsigned IRQ_XF = 1;
   localparam int unsigned IRQ_DI = 2;

endpackage

// File: rtl/epctl_regfile.sv
module epctl_regfile
   import usb_epctl_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned MPS_W  = 11,
   parameter bit          IS_EP0 = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              core_set_nak,
   input  logic              hw_clr_ena,
   output ctl_s              ctl,
   output logic [MPS_W-1:0]  mps_raw
);

   logic ena_q, dis_q, nak_q, stall_q;
   logic nak_set, nak_clr;

   assign nak_set = core_set_nak | (wr & wdata[B_SNAK]);
   assign nak_clr = wr & wdata[B_CNAK];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ena_q   <= 1'b0;
         dis_q   <= 1'b0;
         nak_q   <= 1'b0;
         stall_q <= 1'b0;
      end else begin
         if (hw_clr_ena)
            ena_q <= 1'b0;
         else if (wr && wdata[B_ENA])
            ena_q <= 1'b1;

         if (hw_clr_ena)
            dis_q <= 1'b0;
         else if (wr && wdata[B_DIS] && ena_q)
            dis_q <= 1'b1;

         if (nak_set)
            nak_q <= 1'b1;
         else if (nak_clr)
            nak_q <= 1'b0;

         if (wr)
            stall_q <= wdata[B_STALL];
      end
   end

   generate
      if (IS_EP0) begin : g_ctl_ep
         logic [1:0] code_q;
         always_ff @(posedge clk) begin
            if (!rst_n)
               code_q <= 2'b00;
            else if (wr)
               code_q <= wdata[1:0];
         end
         assign mps_raw = {{(MPS_W-2){1'b0}}, code_q};
         assign ctl.act = 1'b1;
      end else begin : g_gen_ep
         logic [MPS_W-1:0] size_q;
         logic             act_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               size_q <= '0;
               act_q  <= 1'b0;
            end else if (wr) begin
               size_q <= wdata[MPS_W-1:0];
               act_q  <= wdata[B_ACT];
            end
         end
         assign mps_raw = size_q;
         assign ctl.act = act_q;
      end
   endgenerate

   assign ctl.ena   = ena_q;
   assign ctl.dis   = dis_q;
   assign ctl.nak   = nak_q;
   assign ctl.stall = stall_q;

   logic wdata_unused;
   assign wdata_unused = ^wdata;

endmodule

// File: rtl/epctl_handshake.sv
module epctl_handshake
   import usb_epctl_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic tok_valid,
   input  logic tok_setup,
   input  logic fifo_has_data,
   input  ctl_s ctl,
   output logic hs_valid,
   output hs_e  hs_code
);

   hs_e decide;

   always_comb begin
      if (tok_setup)
         decide = HS_ACK;
      else if (ctl.stall)
         decide = HS_STALL;
      else if (ctl.nak || !ctl.ena || !fifo_has_data)
         decide = HS_NAK;
      else
         decide = HS_DATA;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hs_valid <= 1'b0;
         hs_code  <= HS_NAK;
      end else begin
         hs_valid <= tok_valid;
         if (tok_valid)
            hs_code <= decide;
      end
   end

   logic act_unused;
   assign act_unused = ctl.act ^ ctl.dis;

endmodule

// File: rtl/epctl_irqseq.sv
module epctl_irqseq
   import usb_epctl_pkg::*;
#(
   parameter int unsigned IRQ_GAP = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             setup_done,
   input  logic             xfer_done,
   input  logic             ena,
   input  logic             dis,
   output logic             clr_ena,
   output logic [N_IRQ-1:0] irq
);

   logic [N_IRQ-1:0] ev;

   always_comb begin
      ev         = '0;
      ev[IRQ_SU] = setup_done;
      ev[IRQ_XF] = xfer_done;
      ev[IRQ_DI] = ena & dis;
   end

   assign clr_ena = |ev;

   logic [N_IRQ-1:0] stage [IRQ_GAP+1];

   assign stage[0] = ev;

   for (genvar g = 0; g < IRQ_GAP; g++) begin : g_lag
      logic [N_IRQ-1:0] q;
      always_ff @(posedge clk) begin
         if (!rst_n)
            q <= '0;
         else
            q <= stage[g];
      end
      assign stage[g+1] = q;
   end

   logic [N_IRQ-1:0] out_q;
   always_ff @(posedge clk) begin
      if (!rst_n)
         out_q <= '0;
      else
         out_q <= stage[IRQ_GAP];
   end

   assign irq = out_q;

endmodule

// File: rtl/usb_ep_ctrl.sv
module usb_ep_ctrl
   import usb_epctl_pkg::*;
#(
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned MPS_W   = 11,
   parameter bit          IS_EP0  = 1'b1,
   parameter int unsigned IRQ_GAP = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              tok_valid,
   input  logic              tok_setup,
   input  logic              fifo_has_data,
   input  logic              core_set_nak,
   input  logic              setup_done,
   input  logic              xfer_done,
   output logic              hs_valid,
   output logic [1:0]        hs_code,
   output logic [MPS_W-1:0]  mps_bytes,
   output logic              irq_setup_done,
   output logic              irq_xfer_done,
   output logic              irq_ep_disabled
);

   initial begin
      if (DATA_W <= TOP_BIT)
         $error("usb_ep_ctrl: DATA_W too small for control word");
      if (MPS_W < 7 || MPS_W > B_ACT)
         $error("usb_ep_ctrl: MPS_W must lie in 7..11");
      if (IRQ_GAP < 1)
         $error("usb_ep_ctrl: IRQ_GAP must be at least 1");
   end

   ctl_s             ctl;
   logic [MPS_W-1:0] mps_raw;
   logic             clr_ena;
   logic [N_IRQ-1:0] irq;
   hs_e              hs_dec;

   epctl_regfile #(
      .DATA_W (DATA_W),
      .MPS_W  (MPS_W),
      .IS_EP0 (IS_EP0)
   ) u_regs (
      .clk          (clk),
      .rst_n        (rst_n),
      .wr           (reg_wr),
      .wdata        (reg_wdata),
      .core_set_nak (core_set_nak),
      .hw_clr_ena   (clr_ena),
      .ctl          (ctl),
      .mps_raw      (mps_raw)
   );

   epctl_handshake u_hs (
      .clk           (clk),
      .rst_n         (rst_n),
      .tok_valid     (tok_valid),
      .tok_setup     (tok_setup),
      .fifo_has_data (fifo_has_data),
      .ctl           (ctl),
      .hs_valid      (hs_valid),
      .hs_code       (hs_dec)
   );

   epctl_irqseq #(
      .IRQ_GAP (IRQ_GAP)
   ) u_irq (
      .clk        (clk),
      .rst_n      (rst_n),
      .setup_done (setup_done),
      .xfer_done  (xfer_done),
      .ena        (ctl.ena),
      .dis        (ctl.dis),
      .clr_ena    (clr_ena),
      .irq        (irq)
   );

   assign hs_code         = hs_dec;
   assign irq_setup_done  = irq[IRQ_SU];
   assign irq_xfer_done   = irq[IRQ_XF];
   assign irq_ep_disabled = irq[IRQ_DI];

   generate
      if (IS_EP0) begin : g_dec_ctl
         localparam logic [MPS_W-1:0] MAX_BYTES = MPS_W'(64);
         assign mps_bytes = MAX_BYTES >> mps_raw[1:0];
      end else begin : g_dec_raw
         assign mps_bytes = mps_raw;
      end
   endgenerate

   always_comb begin
      reg_rdata              = '0;
      reg_rdata[MPS_W-1:0]   = mps_raw;
      reg_rdata[B_ACT]       = ctl.act;
      reg_rdata[B_NAK]       = ctl.nak;
      reg_rdata[B_STALL]     = ctl.stall;
      reg_rdata[B_DIS]       = ctl.dis;
      reg_rdata[B_ENA]       = ctl.ena;
   end

endmodule

// File: rtl/usb_ep_ctrl_sva.sv
module usb_ep_ctrl_sva
   import usb_epctl_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned MPS_W  = 11,
   parameter bit          IS_EP0 = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_wr,
   input logic [DATA_W-1:0] reg_wdata,
   input logic [DATA_W-1:0] reg_rdata,
   input logic              tok_valid,
   input logic              tok_setup,
   input logic              setup_done,
   input logic              xfer_done,
   input logic              hs_valid,
   input logic [1:0]        hs_code,
   input logic              irq_setup_done,
   input logic              irq_xfer_done,
   input logic              irq_ep_disabled
);

   logic ena, dis, nak, stall;
   assign ena   = reg_rdata[B_ENA];
   assign dis   = reg_rdata[B_DIS];
   assign nak   = reg_rdata[B_NAK];
   assign stall = reg_rdata[B_STALL];

   // R4
   a_r4_setup_acked: assert property (@(posedge clk) disable iff (!rst_n)
      tok_valid && tok_setup |=> hs_valid && hs_code == 2'd1);

   // R5
   a_r5_stall_first: assert property (@(posedge clk) disable iff (!rst_n)
      tok_valid && !tok_setup && stall |=> hs_valid && hs_code == 2'd3);

   // R2
   a_r2_nak_overrides: assert property (@(posedge clk) disable iff (!rst_n)
      tok_valid && !tok_setup && !stall && nak |=> hs_code == 2'd2);

   // R6
   a_r6_cmd_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_rdata[B_SNAK] && !reg_rdata[B_CNAK]);

   // R6
   a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr && reg_wdata[B_SNAK] |=> nak);

   // R9
   a_r9_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
      setup_done || xfer_done |=> !ena);

   // R9 / R10: every interrupt follows a cycle with enable at 0
   a_r9_irq_after_clear: assert property (@(posedge clk) disable iff (!rst_n)
      irq_setup_done || irq_xfer_done || irq_ep_disabled |-> $past(!ena));

   // R10
   a_r10_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
      ena && dis |=> !ena && !dis);

   // R11
   a_r11_hw_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr && reg_wdata[B_ENA] && (setup_done || xfer_done) |=> !ena);

   generate
      if (IS_EP0) begin : g_ep0_chk
         // R8
         a_r8_active_set: assert property (@(posedge clk) disable iff (!rst_n)
            reg_rdata[B_ACT]);
      end
   endgenerate

   logic bits_unused;
   assign bits_unused = ^reg_wdata ^ ^reg_rdata;

endmodule

bind usb_ep_ctrl usb_ep_ctrl_sva #(
   .DATA_W (DATA_W),
   .MPS_W  (MPS_W),
   .IS_EP0 (IS_EP0)
) u_sva (
   .clk             (clk),
   .rst_n           (rst_n),
   .reg_wr          (reg_wr),
   .reg_wdata       (reg_wdata),
   .reg_rdata       (reg_rdata),
   .tok_valid       (tok_valid),
   .tok_setup       (tok_setup),
   .setup_done      (setup_done),
   .xfer_done       (xfer_done),
   .hs_valid        (hs_valid),
   .hs_code         (hs_code),
   .irq_setup_done  (irq_setup_done),
   .irq_xfer_done   (irq_xfer_done),
   .irq_ep_disabled (irq_ep_disabled)
);

// File: tb/usb_ep_ctrl_tb.sv
module usb_ep_ctrl_tb;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic        reg_wr = 0;
   logic [31:0] reg_wdata = '0;
   logic        tok_valid = 0, tok_setup = 0, fifo_has_data = 0;
   logic        core_set_nak = 0, setup_done = 0, xfer_done = 0;

   logic [31:0] rd0, rd1;
   logic        hv0, hv1, is0, ix0, id0, is1, ix1, id1;
   logic [1:0]  hc0, hc1;
   logic [10:0] mb0, mb1;

   usb_ep_ctrl #(.IS_EP0(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
      .reg_rdata(rd0), .tok_valid(tok_valid), .tok_setup(tok_setup),
      .fifo_has_data(fifo_has_data), .core_set_nak(core_set_nak),
      .setup_done(setup_done), .xfer_done(xfer_done), .hs_valid(hv0),
      .hs_code(hc0), .mps_bytes(mb0), .irq_setup_done(is0),
      .irq_xfer_done(ix0), .irq_ep_disabled(id0));

   usb_ep_ctrl #(.IS_EP0(1'b0)) u_dut_gen (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
      .reg_rdata(rd1), .tok_valid(tok_valid), .tok_setup(tok_setup),
      .fifo_has_data(fifo_has_data), .core_set_nak(core_set_nak),
      .setup_done(setup_done), .xfer_done(xfer_done), .hs_valid(hv1),
      .hs_code(hc1), .mps_bytes(mb1), .irq_setup_done(is1),
      .irq_xfer_done(ix1), .irq_ep_disabled(id1));

   typedef struct packed {
      logic ena, dis, nak, stall, act;
      logic [10:0] mps;
      logic [2:0]  pend, irq;
      logic        hsv;
      logic [1:0]  hsc;
   } mdl_t;

   mdl_t m0, m1;
   int checks = 0, fails = 0;
   bit done = 0;

   function automatic mdl_t mdl_reset(bit ep0);
      mdl_t r = '0;
      r.act = ep0;
      return r;
   endfunction

   function automatic logic [1:0] exp_code(mdl_t s);
      if (tok_setup) return 2'd1;
      if (s.stall) return 2'd3;
      if (s.nak || !s.ena || !fifo_has_data) return 2'd2;
      return 2'd0;
   endfunction

   function automatic mdl_t mdl_next(mdl_t s, bit ep0);
      mdl_t n = s;
      logic ev_dis, clr;
      ev_dis = s.ena & s.dis;
      clr = setup_done | xfer_done | ev_dis;
      n.hsv = tok_valid;
      if (tok_valid) n.hsc = exp_code(s);
      n.irq = s.pend;
      n.pend = {ev_dis, xfer_done, setup_done};
      n.ena = clr ? 1'b0 : ((reg_wr & reg_wdata[21]) ? 1'b1 : s.ena);
      n.dis = clr ? 1'b0 : ((reg_wr & reg_wdata[20] & s.ena) ? 1'b1 : s.dis);
      if (core_set_nak || (reg_wr && reg_wdata[16])) n.nak = 1'b1;
      else if (reg_wr && reg_wdata[17]) n.nak = 1'b0;
      if (reg_wr) begin
         n.stall = reg_wdata[13];
         n.act = ep0 ? 1'b1 : reg_wdata[11];
         n.mps = ep0 ? {9'b0, reg_wdata[1:0]} : reg_wdata[10:0];
      end
      return n;
   endfunction

   function automatic logic [31:0] exp_rd(mdl_t s);
      return {10'b0, s.ena, s.dis, 6'b0, s.stall, s.nak, s.act, s.mps};
   endfunction

   function automatic logic [10:0] exp_mps(mdl_t s, bit ep0);
      return ep0 ? (11'd64 >> s.mps[1:0]) : s.mps;
   endfunction

   task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   function automatic string hs_tag(mdl_t s);
      if (s.hsc == 2'd1) return "R4";
      if (s.hsc == 2'd3) return "R5";
      if (s.hsc == 2'd2 && s.nak) return "R2";
      return "R3";
   endfunction

   task automatic compare(string tag);
      chk(tag, "ep0 rdata", rd0, exp_rd(m0));
      chk(tag, "gen rdata", rd1, exp_rd(m1));
      chk("R2", "ep0 hs_valid", {31'b0, hv0}, {31'b0, m0.hsv});
      chk("R2", "gen hs_valid", {31'b0, hv1}, {31'b0, m1.hsv});
      if (m0.hsv) chk(hs_tag(m0), "ep0 hs_code", {30'b0, hc0}, {30'b0, m0.hsc});
      if (m1.hsv) chk(hs_tag(m1), "gen hs_code", {30'b0, hc1}, {30'b0, m1.hsc});
      chk("R9", "ep0 irq", {29'b0, id0, ix0, is0}, {29'b0, m0.irq});
      chk("R10", "gen irq", {29'b0, id1, ix1, is1}, {29'b0, m1.irq});
      chk("R7", "ep0 mps_bytes", {21'b0, mb0}, {21'b0, exp_mps(m0, 1'b1)});
      chk("R7", "gen mps_bytes", {21'b0, mb1}, {21'b0, exp_mps(m1, 1'b0)});
   endtask

   task automatic idle_inputs();
      reg_wr = 0; reg_wdata = '0; tok_valid = 0; tok_setup = 0;
      fifo_has_data = 0; core_set_nak = 0; setup_done = 0; xfer_done = 0;
   endtask

   // Inputs are already driven (after a negedge); advance one edge and check.
   task automatic step(string tag);
      m0 = mdl_next(m0, 1'b1);
      m1 = mdl_next(m1, 1'b0);
      @(posedge clk);
      #2;
      compare(tag);
      @(negedge clk);
      idle_inputs();
   endtask

   task automatic wr(logic [31:0] d, string tag);
      reg_wr = 1; reg_wdata = d;
      step(tag);
   endtask

   task automatic tok(bit setup, bit fifo, string tag);
      tok_valid = 1; tok_setup = setup; fifo_has_data = fifo;
      step(tag);
   endtask

   initial begin
      void'($urandom(32'd20240611));
      m0 = mdl_reset(1'b1);
      m1 = mdl_reset(1'b0);
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1 reset words
      chk("R1", "ep0 reset word", rd0, 32'h0000_0800);
      chk("R1", "gen reset word", rd1, 32'h0);
      chk("R1", "reset hs/irq", {24'b0, hv0, hv1, is0, ix0, id0, is1, ix1, id1}, 32'h0);

      // R7 packet-size decode, R8 active bit sticks at 1 on EP0
      for (int c = 0; c < 4; c++) begin
         wr(32'h0000_0000 | c, "R8");
         chk("R7", "ep0 decode", {21'b0, mb0}, 32'd64 >> c);
      end
      wr(32'h0000_0004, "R7");

      // R3 disabled endpoint naks; enable; data vs empty FIFO
      tok(0, 1, "R3");
      wr(32'h0020_0000, "R9");
      tok(0, 1, "R3");
      chk("R3", "data on fifo", {30'b0, hc0}, 32'd0);
      tok(0, 0, "R3");
      chk("R3", "nak on empty", {30'b0, hc0}, 32'd2);

      // R2 NAK flag overrides waiting data; R6 set and clear together
      wr(32'h0023_0000, "R6");
      chk("R6", "set beats clear", {31'b0, rd0[12]}, 32'd1);
      tok(0, 1, "R2");
      chk("R2", "nak with data", {30'b0, hc0}, 32'd2);
      wr(32'h0002_0000, "R6");
      core_set_nak = 1; reg_wr = 1; reg_wdata = 32'h0002_0000;
      step("R6");
      chk("R6", "core set beats clear", {31'b0, rd0[12]}, 32'd1);
      wr(32'h0002_0000, "R6");

      // R5 stall first; R4 setup acked while stalled
      wr(32'h0001_2000, "R5");
      tok(0, 1, "R5");
      chk("R5", "stall code", {30'b0, hc0}, 32'd3);
      tok(1, 0, "R4");
      chk("R4", "setup ack", {30'b0, hc0}, 32'd1);
      wr(32'h0002_0000, "R5");

      // R9 transfer done: clear, then pulse
      xfer_done = 1; step("R9");
      chk("R9", "ena cleared", {31'b0, rd0[21]}, 32'd0);
      chk("R9", "no early irq", {31'b0, ix0}, 32'd0);
      step("R9");
      chk("R9", "irq pulse", {31'b0, ix0}, 32'd1);
      step("R9");
      chk("R9", "pulse ends", {31'b0, ix0}, 32'd0);

      // R10 disable while disabled ignored, then real disable
      wr(32'h0010_0000, "R10");
      chk("R10", "ignored disable", {31'b0, rd0[20]}, 32'd0);
      wr(32'h0020_0000, "R10");
      wr(32'h0010_0000, "R10");
      chk("R10", "disable held", {30'b0, rd0[21:20]}, 32'd3);
      step("R10");
      chk("R10", "both cleared", {30'b0, rd0[21:20]}, 32'd0);
      step("R10");
      chk("R10", "disable irq", {31'b0, id0}, 32'd1);

      // R11 hardware clear wins over software set
      setup_done = 1; reg_wr = 1; reg_wdata = 32'h0020_0000;
      step("R11");
      chk("R11", "ena stays 0", {31'b0, rd0[21]}, 32'd0);
      step("R9");

      // Random phase
      for (int i = 0; i < 4000; i++) begin
         logic [31:0] d;
         tok_valid = ($urandom % 100) < 35;
         tok_setup = ($urandom % 100) < 20;
         fifo_has_data = $urandom % 2;
         core_set_nak = ($urandom % 100) < 3;
         setup_done = ($urandom % 100) < 3;
         xfer_done = ($urandom % 100) < 4;
         reg_wr = ($urandom % 100) < 15;
         d = $urandom;
         d[21] = ($urandom % 100) < 50;
         d[20] = ($urandom % 100) < 20;
         d[16] = ($urandom % 100) < 15;
         d[17] = ($urandom % 100) < 25;
         d[13] = ($urandom % 100) < 15;
         reg_wdata = d;
         step("R9");
      end

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule